// File: doc/BRIEF.md
# External Interrupt Detector and Gate

This block watches a small set of active-low interrupt pins on behalf of a microcontroller core. Every pin is brought into the clock domain through a flop chain. A per-source mode bit then selects between latching a falling edge and following a low level. The resulting pending flag is masked by a per-source enable and by one global enable. A fixed-priority picker presents a single request and the index of the winning source to the core.

When the core takes the vector, it pulses an acknowledge. That pulse clears the pending flag of the source currently presented. In level mode the flag simply tracks the pin, so releasing the pin withdraws an unserviced request. Software reaches every control and flag bit through a single-bit write port and a registered single-bit read port.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A synchronous reset clears every pending flag, every mode bit, every source enable and the global enable. After reset `irq_req` is 0, and every bit read through the bit port returns 0.
- R2: Mode bit 1 selects edge mode. A high-to-low transition on a pin, held for at least two clocks, sets that source's pending flag exactly three rising edges after the pin is driven low. The flag then stays set after the pin returns high.
- R3: Mode bit 0 selects level mode. In this mode the pending flag equals the inverted pin with the same three-edge latency, so raising the pin clears an unserviced flag.
- R4: In edge mode, an `irq_ack` pulse sampled while `irq_req` is 1 clears the flag of the source named by `irq_id`. `irq_req` falls on that same edge when no other source is ready.
- R5: A pending source raises `irq_req` only while its enable bit is 1.
- R6: While the global enable is 0, `irq_req` is 0 whatever the flags and source enables hold.
- R7: When several sources are ready, the lowest index is presented first. `irq_id` carries the source number in binary: 0 for pin 0, 1 for pin 1.
- R8: Bit addresses are: 0 = mode of source 0, 1 = flag of source 0, 2 = mode of source 1, 3 = flag of source 1, 4 = enable of source 0, 5 = enable of source 1, 7 = global enable. Address 6 reads 0 and ignores writes. `bit_rdata` shows the addressed bit one clock after the address is applied.
- R9: A software write to a flag bit in edge mode takes effect on the next clock. When a hardware set and a software clear fall on the same edge, the hardware set wins.
- R10: In level mode, software writes to the flag bit and `irq_ack` leave the flag unchanged. It keeps following the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | NUM_SRC | Active-low asynchronous interrupt pins |
| bit_we | input | 1 | Bit write strobe |
| bit_addr | input | ADDR_W | Bit address for write and read |
| bit_wdata | input | 1 | Value to write |
| bit_rdata | output | 1 | Registered value of the addressed bit |
| irq_ack | input | 1 | Core has entered the service routine of the presented source |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_id | output | ID_W | Registered index of the presented source |

## Verification
The pins are exercised in four ways:
- A short low pulse in edge mode separates latching from tracking.
- A held low level in level mode followed by release shows that the request is withdrawn.
- Both pins low together exposes the priority order and the hand-over after an acknowledge.
- A software clear placed on the very edge where a falling edge lands shows which of the two wins.

Enables and the global bit are toggled with a flag already pending, which shows that they mask the flag without erasing it. A behavioural reference model runs alongside and is compared on every clock.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  function automatic int unsigned addr_bits(input int unsigned n_src);
    return $clog2(3 * n_src + 1);
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_src_cell.sv
module ext_irq_src_cell
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic mode_we,
  input  logic flag_we,
  input  logic wdata,
  input  logic ack_clr,
  output logic mode_o,
  output logic flag_o,
  output logic flag_next_o
);
  trig_e mode_q, mode_d;
  logic  flag_q, flag_d;
  logic  prev_q;
  logic  fall;

  assign fall = prev_q & ~pin_s;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = wdata ? TRIG_FALL : TRIG_LEVEL;
  end

  always_comb begin
    if (mode_d == TRIG_LEVEL) begin
      flag_d = ~pin_s;
    end else if (fall) begin
      flag_d = 1'b1;
    end else if (ack_clr) begin
      flag_d = 1'b0;
    end else if (flag_we) begin
      flag_d = wdata;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TRIG_LEVEL;
      flag_q <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      mode_q <= mode_d;
      flag_q <= flag_d;
      prev_q <= pin_s;
    end
  end

  assign mode_o      = (mode_q == TRIG_FALL);
  assign flag_o      = flag_q;
  assign flag_next_o = flag_d;

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (mode_d == TRIG_FALL && fall) |=> flag_q); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (mode_d == TRIG_FALL && ack_clr && !fall) |=> !flag_q); // R4
endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio #(
  parameter int unsigned N   = 2,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  ready_i,
  output logic          any_o,
  output logic [IW-1:0] id_o
);
  always_comb begin
    any_o = |ready_i;
    id_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ready_i[i]) id_o = IW'(i);
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = addr_bits(NUM_SRC),
  localparam int unsigned ID_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_pin_n,
  input  logic               bit_we,
  input  logic [ADDR_W-1:0]  bit_addr,
  input  logic               bit_wdata,
  output logic               bit_rdata,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [ID_W-1:0]    irq_id
);
  localparam int unsigned EN_BASE   = 2 * NUM_SRC;
  localparam int unsigned GLOB_ADDR = (1 << ADDR_W) - 1;

  logic [NUM_SRC-1:0] pin_s;
  logic [NUM_SRC-1:0] mode_q, flag_q, flag_d;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic               glob_q, glob_d;
  logic [NUM_SRC-1:0] ready_d;
  logic               any_d;
  logic [ID_W-1:0]    id_d;
  logic               rdata_d;

  ext_irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(irq_pin_n), .sync_o(pin_s)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic mode_we_g, flag_we_g, ack_g;
    assign mode_we_g = bit_we && (bit_addr == ADDR_W'(2 * g));
    assign flag_we_g = bit_we && (bit_addr == ADDR_W'(2 * g + 1));
    assign ack_g     = irq_ack && irq_req && (irq_id == ID_W'(g));

    ext_irq_src_cell u_cell (
      .clk(clk), .rst(rst), .pin_s(pin_s[g]),
      .mode_we(mode_we_g), .flag_we(flag_we_g), .wdata(bit_wdata),
      .ack_clr(ack_g), .mode_o(mode_q[g]), .flag_o(flag_q[g]),
      .flag_next_o(flag_d[g])
    );

    always_comb begin
      en_d[g] = en_q[g];
      if (bit_we && bit_addr == ADDR_W'(EN_BASE + g)) en_d[g] = bit_wdata;
    end
  end

  always_comb begin
    glob_d = glob_q;
    if (bit_we && bit_addr == ADDR_W'(GLOB_ADDR)) glob_d = bit_wdata;
  end

  assign ready_d = glob_d ? (flag_d & en_d) : '0;

  ext_irq_prio #(.N(NUM_SRC)) u_prio (
    .ready_i(ready_d), .any_o(any_d), .id_o(id_d)
  );

  always_comb begin
    rdata_d = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (bit_addr == ADDR_W'(2 * i))       rdata_d = mode_q[i];
      if (bit_addr == ADDR_W'(2 * i + 1))   rdata_d = flag_q[i];
      if (bit_addr == ADDR_W'(EN_BASE + i)) rdata_d = en_q[i];
    end
    if (bit_addr == ADDR_W'(GLOB_ADDR)) rdata_d = glob_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      glob_q    <= 1'b0;
      irq_req   <= 1'b0;
      irq_id    <= '0;
      bit_rdata <= 1'b0;
    end else begin
      en_q      <= en_d;
      glob_q    <= glob_d;
      irq_req   <= any_d;
      irq_id    <= id_d;
      bit_rdata <= rdata_d;
    end
  end

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    !glob_q |-> !irq_req); // R6

  AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (flag_q[irq_id] && en_q[irq_id])); // R5

  AST_LOW_INDEX_FIRST: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_id != '0) |-> !(flag_q[0] && en_q[0])); // R7

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!irq_req && !bit_rdata)); // R1
endmodule

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] irq_pin_n = 2'b11;
  logic       bit_we = 1'b0;
  logic [2:0] bit_addr = 3'd0;
  logic       bit_wdata = 1'b0;
  logic       bit_rdata;
  logic       irq_ack = 1'b0;
  logic       irq_req;
  logic [0:0] irq_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst(rst), .irq_pin_n(irq_pin_n), .bit_we(bit_we),
    .bit_addr(bit_addr), .bit_wdata(bit_wdata), .bit_rdata(bit_rdata),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_id(irq_id)
  );

  // behavioural reference state
  int m_s1[2], m_s2[2], m_prev[2], m_mode[2], m_flag[2], m_en[2];
  int m_glob, m_req, m_id, m_rd;

  always @(posedge clk) begin
    int fall[2], nflag[2], nmode[2], nen[2], nglob, bits[8], rdy;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_s1[i] = 1; m_s2[i] = 1; m_prev[i] = 1;
        m_mode[i] = 0; m_flag[i] = 0; m_en[i] = 0;
      end
      m_glob = 0; m_req = 0; m_id = 0; m_rd = 0;
    end else begin
      for (int b = 0; b < 8; b++) bits[b] = 0;
      bits[0] = m_mode[0]; bits[1] = m_flag[0];
      bits[2] = m_mode[1]; bits[3] = m_flag[1];
      bits[4] = m_en[0];   bits[5] = m_en[1];  bits[7] = m_glob;
      m_rd = bits[bit_addr];
      nglob = (bit_we && bit_addr == 7) ? int'(bit_wdata) : m_glob;
      for (int i = 0; i < 2; i++) begin
        fall[i]  = (m_prev[i] == 1 && m_s2[i] == 0);
        nmode[i] = (bit_we && bit_addr == 2*i)   ? int'(bit_wdata) : m_mode[i];
        nen[i]   = (bit_we && bit_addr == 4 + i) ? int'(bit_wdata) : m_en[i];
        if (nmode[i] == 0) nflag[i] = !m_s2[i];
        else if (fall[i]) nflag[i] = 1;
        else if (irq_ack && m_req == 1 && m_id == i) nflag[i] = 0;
        else if (bit_we && bit_addr == 2*i + 1) nflag[i] = bit_wdata;
        else nflag[i] = m_flag[i];
      end
      for (int i = 0; i < 2; i++) begin
        m_prev[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = irq_pin_n[i];
        m_mode[i] = nmode[i]; m_flag[i] = nflag[i]; m_en[i] = nen[i];
      end
      m_glob = nglob;
      rdy = 0;
      m_id = 0;
      if (m_glob) begin
        if (m_flag[1] && m_en[1]) begin rdy = 1; m_id = 1; end
        if (m_flag[0] && m_en[0]) begin rdy = 1; m_id = 0; end
      end
      m_req = rdy;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(irq_req == m_req, "MODEL req", irq_req, m_req);
      if (m_req) check(irq_id == m_id, "MODEL id", irq_id, m_id);
      check(bit_rdata == m_rd, "MODEL rdata", bit_rdata, m_rd);
    end
  end

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wbit(input int a, input bit v);
    @(negedge clk);
    bit_we = 1'b1; bit_addr = 3'(a); bit_wdata = v;
    @(negedge clk);
    bit_we = 1'b0;
  endtask

  task automatic rbit(input int a, output bit v);
    @(negedge clk);
    bit_addr = 3'(a);
    @(negedge clk);
    v = bit_rdata;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit v;
    cyc(3);
    @(negedge clk) rst = 1'b0;
    check(irq_req == 0, "R1 req after reset", irq_req, 0);
    for (int a = 0; a < 8; a++) begin
      rbit(a, v);
      check(v == 0, "R1 reset bit", v, 0);
    end

    // R8: unused address ignores writes
    wbit(6, 1); rbit(6, v);
    check(v == 0, "R8 addr 6 reads 0", v, 0);

    // R2: edge mode latches a short pulse
    wbit(0, 1); wbit(4, 1); wbit(7, 1);
    rbit(0, v); check(v == 1, "R8 mode0 readback", v, 1);
    @(negedge clk) irq_pin_n[0] = 1'b0;
    cyc(3);
    check(irq_req == 1 && irq_id == 0, "R2 edge sets request", irq_req, 1);
    irq_pin_n[0] = 1'b1;
    cyc(6);
    check(irq_req == 1, "R2 flag held after release", irq_req, 1);

    // R4: ack clears the presented flag
    ack();
    check(irq_req == 0, "R4 ack drops request", irq_req, 0);
    rbit(1, v); check(v == 0, "R4 flag0 cleared", v, 0);

    // R3: level mode tracks pin on source 1
    wbit(5, 1);
    @(negedge clk) irq_pin_n[1] = 1'b0;
    cyc(3);
    check(irq_req == 1 && irq_id == 1, "R3 level raises request", irq_id, 1);

    // R10: sw clear and ack have no effect in level mode
    wbit(3, 0); rbit(3, v);
    check(v == 1, "R10 sw write ignored in level mode", v, 1);
    ack(); cyc(1);
    check(irq_req == 1, "R10 ack ignored in level mode", irq_req, 1);

    // R7: both ready, source 0 wins
    @(negedge clk) irq_pin_n[0] = 1'b0;
    cyc(3);
    check(irq_req == 1 && irq_id == 0, "R7 source 0 first", irq_id, 0);
    irq_pin_n[0] = 1'b1;
    ack();
    check(irq_req == 1 && irq_id == 1, "R7 source 1 next", irq_id, 1);

    @(negedge clk) irq_pin_n[1] = 1'b1;
    cyc(3);
    check(irq_req == 0, "R3 release withdraws", irq_req, 0);

    // R9 / R5 / R6: sw set, masking
    wbit(4, 0); wbit(1, 1);
    rbit(1, v); check(v == 1, "R9 sw set flag0", v, 1);
    check(irq_req == 0, "R5 enable off masks", irq_req, 0);
    wbit(4, 1); cyc(1);
    check(irq_req == 1, "R5 enable on forwards", irq_req, 1);
    wbit(7, 0); cyc(1);
    check(irq_req == 0, "R6 global off masks", irq_req, 0);
    wbit(7, 1); cyc(1);
    check(irq_req == 1, "R6 global on forwards", irq_req, 1);
    wbit(1, 0); cyc(1);
    check(irq_req == 0, "R9 sw clear flag0", irq_req, 0);

    // R9: hardware set beats sw clear on the same edge
    @(negedge clk) irq_pin_n[0] = 1'b0;
    cyc(2);
    bit_we = 1'b1; bit_addr = 3'd1; bit_wdata = 1'b0;
    @(negedge clk) bit_we = 1'b0;
    irq_pin_n[0] = 1'b1;
    rbit(1, v);
    check(v == 1, "R9 hw set wins", v, 1);
    check(irq_req == 1, "R9 request after collision", irq_req, 1);

    cyc(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule